// File: doc/BRIEF.md
# Three-Level Differential PWM Modulator

The modulator turns one signed audio sample per switching period into two single-bit bridge drive signals, P and N. An up/down triangle carrier counter runs off the system clock. Each output is high while the carrier sits below its own threshold. The P threshold is half-scale plus the sample, and the N threshold is half-scale minus the sample. With a zero sample, both legs switch together at 50 % duty, so the load sees no differential voltage. A nonzero sample widens the pulse on one leg and narrows it by the same amount on the other. The two legs then differ only in a short window around each pulse edge.

New samples, the frequency choice and the mute request are all taken at the carrier minimum, which is the period boundary. A pulse is therefore never reshaped partway through a period. One select input chooses between two carrier half-lengths. These are derived from the clock rate and the two target switching frequencies (400 kHz and 500 kHz by default). Samples are clamped so that the narrower pulse never falls below two clocks.

Top module: `pwm3_mod`

## Requirements
- R1: While reset is held, and in the first clock after reset is released, both outputs are low. The block leaves reset muted and applies the mute input at the first period boundary.
- R2: With a sample of zero, P and N carry identical waveforms, each high for H of the 2H clocks in a period. H is the active carrier half-length.
- R3: With a positive two's-complement sample s (after clamping), P is high for H+2s clocks per period and N is high for H-2s clocks.
- R4: With a negative sample s (after clamping), N is high for H+2|s| clocks per period and P is high for H-2|s| clocks.
- R5: The shorter pulse lies entirely inside the longer one, so the legs differ on exactly 4|s| clocks per period, all of them on the side given by the sample's sign.
- R6: A period lasts 2*H_SLOW clocks (400 kHz by default) while the frequency select is 0, and 2*H_FAST clocks (500 kHz) while it is 1. A change of the select takes effect at a period boundary.
- R7: The sample magnitude is clamped to H/2-1, so at full scale the shorter pulse is exactly 2 clocks long and neither leg reaches 0 % or 100 % duty.
- R8: The sample is captured only at the period boundary. A change in the middle of a period leaves the rest of that period's pulses unchanged.
- R9: Mute takes effect at the next period boundary and drives both outputs low for whole periods. Release also waits for a boundary, after which the duties follow the sample again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | SAMPLE_W | Signed two's-complement audio sample |
| fast_sel_i | input | 1 | 0 selects the slow carrier (F_SLOW), 1 selects the fast carrier (F_FAST) |
| mute_i | input | 1 | Hard mute request; both outputs low from the next boundary |
| out_p_o | output | 1 | Positive bridge leg drive |
| out_n_o | output | 1 | Negative bridge leg drive |

## Verification
The main function is swept over every sample code at both carrier frequencies. For each point the bench counts high clocks on P, high clocks on N, and clocks where the two legs differ. This separates a correct symmetric split from a one-sided, swapped or wrongly scaled split, and the extreme codes expose a missing or off-by-one clamp. Holding a sample at +5 while measuring the distance between rising edges separates the two period lengths. In a separate step, the sample or the mute request is changed just after a falling edge of P, and the bench measures the length of the following low gap and high run. A design that captures inputs before the period boundary produces a different gap or run.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } pwm3_dir_e;

    localparam int NUM_LEGS = 2;
    localparam int LEG_P    = 0;
    localparam int LEG_N    = 1;
endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
    import pwm3_pkg::*;
#(
    parameter int H_SLOW = 250,
    parameter int H_FAST = 200,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_sel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] half_o,
    output logic [CNT_W-1:0] half_nxt_o,
    output logic             bnd_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        pwm3_dir_e        dir;
        logic [CNT_W-1:0] half;
    } car_t;

    car_t car_d, car_q;
    logic bnd;

    assign bnd        = (car_q.dir == DIR_DOWN) && (car_q.cnt == '0);
    assign half_nxt_o = fast_sel_i ? CNT_W'(H_FAST) : CNT_W'(H_SLOW);

    always_comb begin
        car_d = car_q;
        if (bnd) begin
            car_d.cnt  = '0;
            car_d.dir  = DIR_UP;
            car_d.half = half_nxt_o;
        end else if (car_q.dir == DIR_UP) begin
            if (car_q.cnt == car_q.half - CNT_W'(1)) begin
                car_d.dir = DIR_DOWN;
            end else begin
                car_d.cnt = car_q.cnt + CNT_W'(1);
            end
        end else begin
            car_d.cnt = car_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_q.cnt  <= '0;
            car_q.dir  <= DIR_DOWN;
            car_q.half <= CNT_W'(H_SLOW);
        end else begin
            car_q <= car_d;
        end
    end

    assign cnt_o  = car_q.cnt;
    assign half_o = car_q.half;
    assign bnd_o  = bnd;
endmodule

// File: rtl/pwm3_level.sv
module pwm3_level #(
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 8,
    parameter int TW       = 9
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [CNT_W-1:0]    half_i,
    output logic        [TW-1:0]       thr_p_o,
    output logic        [TW-1:0]       thr_n_o
);
    logic signed [TW-1:0] s_ext;
    logic        [TW-1:0] mid, lim, mag, mag_c;
    logic                 neg;

    always_comb begin
        s_ext = TW'(sample_i);
        neg   = sample_i[SAMPLE_W-1];
        mid   = TW'(half_i) >> 1;
        lim   = mid - TW'(1);
        mag   = neg ? TW'(-s_ext) : TW'(s_ext);
        mag_c = (mag > lim) ? lim : mag;
        if (neg) begin
            thr_p_o = mid - mag_c;
            thr_n_o = mid + mag_c;
        end else begin
            thr_p_o = mid + mag_c;
            thr_n_o = mid - mag_c;
        end
    end
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
    parameter int CNT_W = 8,
    parameter int TW    = 9
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [TW-1:0]    thr_i,
    input  logic             en_i,
    output logic             on_o
);
    assign on_o = en_i && (TW'(cnt_i) < thr_i);
endmodule

// File: rtl/pwm3_mod.sv
module pwm3_mod
    import pwm3_pkg::*;
#(
    parameter int CLK_HZ   = 200_000_000,
    parameter int F_SLOW   = 400_000,
    parameter int F_FAST   = 500_000,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic                       fast_sel_i,
    input  logic                       mute_i,
    output logic                       out_p_o,
    output logic                       out_n_o
);
    localparam int H_SLOW = CLK_HZ / (2 * F_SLOW);
    localparam int H_FAST = CLK_HZ / (2 * F_FAST);
    localparam int H_MAX  = (H_SLOW > H_FAST) ? H_SLOW : H_FAST;
    localparam int CNT_W  = $clog2(H_MAX + 1);
    localparam int TW     = ((SAMPLE_W > CNT_W) ? SAMPLE_W : CNT_W) + 1;

    typedef struct packed {
        logic [NUM_LEGS-1:0][TW-1:0] thr;
        logic                        mute;
        logic [NUM_LEGS-1:0]         outs;
    } mod_t;

    mod_t st_d, st_q;

    logic [CNT_W-1:0] cnt, half_q, half_nxt;
    logic             bnd;
    logic [TW-1:0]    lvl_p, lvl_n;
    logic [NUM_LEGS-1:0][TW-1:0] leg_thr;
    logic [NUM_LEGS-1:0]         leg_on;
    logic             mute_q;

    pwm3_carrier #(.H_SLOW(H_SLOW), .H_FAST(H_FAST), .CNT_W(CNT_W)) u_car (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_sel_i (fast_sel_i),
        .cnt_o      (cnt),
        .half_o     (half_q),
        .half_nxt_o (half_nxt),
        .bnd_o      (bnd)
    );

    pwm3_level #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .TW(TW)) u_lvl (
        .sample_i (sample_i),
        .half_i   (half_nxt),
        .thr_p_o  (lvl_p),
        .thr_n_o  (lvl_n)
    );

    assign leg_thr = st_q.thr;
    assign mute_q  = st_q.mute;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pwm3_leg #(.CNT_W(CNT_W), .TW(TW)) u_leg (
            .cnt_i (cnt),
            .thr_i (leg_thr[g]),
            .en_i  (!mute_q),
            .on_o  (leg_on[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bnd) begin
            st_d.thr[LEG_P] = lvl_p;
            st_d.thr[LEG_N] = lvl_n;
            st_d.mute       = mute_i;
        end
        st_d.outs = leg_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr[LEG_P] <= TW'(H_SLOW / 2);
            st_q.thr[LEG_N] <= TW'(H_SLOW / 2);
            st_q.mute       <= 1'b1;
            st_q.outs       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_p_o = st_q.outs[LEG_P];
    assign out_n_o = st_q.outs[LEG_N];
endmodule

// File: rtl/pwm3_mod_chk.sv
module pwm3_mod_chk #(
    parameter int CNT_W = 8,
    parameter int TW    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bnd,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] half,
    input logic [TW-1:0]    thr_p,
    input logic [TW-1:0]    thr_n,
    input logic             mute_q,
    input logic             out_p,
    input logic             out_n
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !out_p && !out_n); // R1
    AST_ZERO_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_p == thr_n) |=> (out_p == out_n)); // R2
    AST_POS_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_p >= thr_n) |=> (out_p || !out_n)); // R5
    AST_NEG_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_n >= thr_p) |=> (out_n || !out_p)); // R5
    AST_SYM_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, thr_p} + {1'b0, thr_n}) == (TW + 1)'(half)); // R3
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_p != '0) && (thr_n != '0) && (thr_p < TW'(half)) && (thr_n < TW'(half))); // R7
    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half); // R6
    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(half)); // R6
    AST_LATCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(thr_p) && $stable(thr_n)); // R8
    AST_MUTE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(mute_q)); // R9
    AST_MUTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mute_q |=> !out_p && !out_n); // R9
endmodule

bind pwm3_mod pwm3_mod_chk #(.CNT_W(CNT_W), .TW(TW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bnd    (bnd),
    .cnt    (cnt),
    .half   (half_q),
    .thr_p  (leg_thr[0]),
    .thr_n  (leg_thr[1]),
    .mute_q (mute_q),
    .out_p  (out_p_o),
    .out_n  (out_n_o)
);

// File: tb/tb_pwm3_mod.sv
`timescale 1ns/1ps
module tb_pwm3_mod;
    localparam int SW = 6;
    localparam int HS = 40;
    localparam int HF = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic fsel = 1'b0;
    logic mute = 1'b0;
    logic op, on;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm3_mod #(.CLK_HZ(200_000_000), .F_SLOW(2_500_000), .F_FAST(3_125_000), .SAMPLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .sample_i(smp), .fast_sel_i(fsel),
        .mute_i(mute), .out_p_o(op), .out_n_o(on)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int s, input int h);
        int lim = h / 2 - 1;
        if (s > lim) return lim;
        if (s < -lim) return -lim;
        return s;
    endfunction

    task automatic wait_level(input logic v);
        while (op !== v) @(negedge clk);
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (op === v) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic window(input int n, output int cp, output int cn, output int cd, output int cw, input bit pos);
        cp = 0; cn = 0; cd = 0; cw = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (op) cp++;
            if (on) cn++;
            if (op != on) cd++;
            if (pos ? (on && !op) : (op && !on)) cw++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cp, cn, cd, cw, h, sc, ga, ru, tA, tB;
        // R1: quiet in reset and on the first clock out of it
        repeat (4) @(negedge clk);
        chk(op == 1'b0 && on == 1'b0, "R1 reset outputs", {op, on}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op == 1'b0 && on == 1'b0, "R1 first cycle after reset", {op, on}, 0);

        // R2 R3 R4 R5 R7: sweep every code at both frequencies
        for (int f = 0; f < 2; f++) begin
            for (int s = -(1 << (SW - 1)); s < (1 << (SW - 1)); s++) begin
                fsel = f[0];
                smp  = SW'(s);
                h    = f ? HF : HS;
                sc   = clampv(s, h);
                repeat (120) @(negedge clk);
                window(2 * h, cp, cn, cd, cw, sc >= 0);
                if (sc == 0) begin
                    chk(cp == h && cn == h && cd == 0, "R2 zero identical", cp * 1000 + cn, h * 1000 + h);
                end else if (sc > 0) begin
                    chk(cp == h + 2 * sc, "R3 P duty", cp, h + 2 * sc);
                    chk(cn == h - 2 * sc, "R3 N duty", cn, h - 2 * sc);
                end else begin
                    chk(cn == h - 2 * sc, "R4 N duty", cn, h - 2 * sc);
                    chk(cp == h + 2 * sc, "R4 P duty", cp, h + 2 * sc);
                end
                chk(cd == 4 * (sc < 0 ? -sc : sc) && cw == 0, "R5 differential", cd * 1000 + cw,
                    4 * (sc < 0 ? -sc : sc) * 1000);
                if (s == (1 << (SW - 1)) - 1 || s == -(1 << (SW - 1)))
                    chk((sc > 0 ? cn : cp) == 2, "R7 min pulse at full scale", sc > 0 ? cn : cp, 2);
            end
        end

        // R6: period from rising edge to rising edge
        for (int f = 0; f < 2; f++) begin
            fsel = f[0];
            smp  = SW'(5);
            h    = f ? HF : HS;
            repeat (200) @(negedge clk);
            wait_level(1'b0);
            wait_level(1'b1);
            run_len(1'b1, ru);
            run_len(1'b0, ga);
            chk(ru + ga == 2 * h, "R6 period length", ru + ga, 2 * h);
        end

        // R8: change the sample just after a P falling edge
        fsel = 1'b0;
        smp  = SW'(5);
        tA   = HS / 2 + 5;
        tB   = HS / 2 - 3;
        repeat (200) @(negedge clk);
        wait_level(1'b1);
        wait_level(1'b0);
        smp = -SW'(3);
        run_len(1'b0, ga);
        chk(ga == 2 * HS - 2 * tA, "R8 gap keeps old sample", ga, 2 * HS - 2 * tA);
        run_len(1'b1, ru);
        chk(ru == tA + tB, "R8 new sample from boundary", ru, tA + tB);

        // R9: mute applied at boundary, then held low, then released
        smp = SW'(5);
        repeat (200) @(negedge clk);
        wait_level(1'b1);
        wait_level(1'b0);
        mute = 1'b1;
        run_len(1'b0, ga);
        chk(ga == 2 * HS - 2 * tA, "R9 mute waits for boundary", ga, 2 * HS - 2 * tA);
        run_len(1'b1, ru);
        chk(ru == tA, "R9 pulse cut at boundary", ru, tA);
        window(4 * HS, cp, cn, cd, cw, 1'b1);
        chk(cp == 0 && cn == 0, "R9 muted low", cp + cn, 0);
        mute = 1'b0;
        repeat (120) @(negedge clk);
        window(2 * HS, cp, cn, cd, cw, 1'b1);
        chk(cp == HS + 10 && cn == HS - 10, "R9 release", cp * 1000 + cn, (HS + 10) * 1000 + HS - 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule